// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave

This block is a slave on a two-wire serial bus (clock line and open-drain data line) that fronts a small byte-wide storage array. Both bus lines are sampled on a fast system clock. The block never drives the data line high. It only asserts a pull-down enable, which the pad turns into a low level. It recognises bus Start and Stop conditions and checks a select byte against a fixed type prefix and two strap inputs. It acknowledges the bytes meant for it, takes a two-byte memory address and stores one data byte.

A byte write is held back until the master closes the transfer with a Stop. The Stop starts a programming interval of a fixed number of system clocks. During that interval `busy_o` is high and the block ignores the bus completely. Reads shift out the byte at the address pointer, most significant bit first. After each byte the pointer moves on, and the read continues for as long as the master acknowledges.

Top module: `twowire_mem_slave`

## Requirements
- R1: A falling data line while the clock line is high is a Start. A rising data line while the clock line is high is a Stop. Clocked bits seen before any Start are ignored and are never acknowledged.
- R2: A Start that arrives in the middle of a transfer abandons it, and a data byte already received in that transfer is not written. The block then expects a new select byte.
- R3: The select byte is sent MSB first. It matches when bits 7..4 are 1010 and bits 2..1 equal the effective strap value {A1,A0}. Bit 3 is not compared. Bit 0 selects the direction: 1 means read and 0 means write.
- R4: A strap bit whose `STRAP_USED` parameter bit is 0 counts as unconnected and reads as 0, whatever level its input pin has.
- R5: After reset, `sda_pull_o` and `busy_o` are 0. For each byte it accepts, the selected slave holds `sda_pull_o` high for the whole ninth clock pulse. On a select byte that does not match, it pulls nothing.
- R6: A write is: select byte with bit 0 = 0, high address byte, low address byte, one data byte, each acknowledged. The data byte is stored only when the Stop arrives.
- R7: The Stop that commits a write holds `busy_o` high for exactly `PROG_CYCLES` system clocks. During that time no select byte is acknowledged and `sda_pull_o` stays low.
- R8: A read drives the byte at the pointer MSB first and changes `sda_pull_o` only while the clock line is low. After each byte the pointer goes up by one. A master no-acknowledge ends the read, and the data line is released.
- R9: Address bits at and above log2(`MEM_DEPTH`) are ignored, so such addresses alias onto the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as received |
| sda_i | input | 1 | Bus data line as received (wired level) |
| strap_i | input | 2 | Device address straps {A1,A0} |
| sda_pull_o | output | 1 | 1 pulls the data line low |
| busy_o | output | 1 | High during the internal programming interval |

## Verification
Two functions can meet in one cycle. One is the Stop that commits a pending write, which starts the programming interval. The other is a Start that comes straight after it. The bench sends a full select byte while `busy_o` is high and expects no acknowledge. It also counts the busy clocks and expects exactly `PROG_CYCLES`. In a second case a repeated Start follows an acknowledged data byte. The bench then checks that no programming interval began and that the target address still reads its old value.

// File: rtl/twm_pkg.sv
package twm_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_TXACK,
        ST_WAIT,
        ST_PROG
    } twm_state_e;

    localparam logic [3:0] TYPE_PREFIX = 4'b1010;
endpackage

// File: rtl/twm_sync.sv
module twm_sync #(
    parameter int WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] hold_q;

    // idle bus level is high on both lines
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '1;
            hold_q <= '1;
        end else begin
            meta_q <= async_i;
            hold_q <= meta_q;
        end
    end

    assign sync_o = hold_q;
endmodule

// File: rtl/twm_mem.sv
module twm_mem #(
    parameter int MEM_DEPTH = 256,
    localparam int AW = $clog2(MEM_DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data
);
    logic [7:0] cell_q [MEM_DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < MEM_DEPTH; i++) cell_q[i] <= 8'h00;
        end else if (wr_en) begin
            cell_q[wr_addr] <= wr_data;
        end
    end

    assign rd_data = cell_q[rd_addr];
endmodule

// File: rtl/twm_core.sv
module twm_core
    import twm_pkg::*;
#(
    parameter int MEM_DEPTH   = 256,
    parameter int PROG_CYCLES = 1000,
    localparam int AW = $clog2(MEM_DEPTH),
    localparam int TW = $clog2(PROG_CYCLES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_s,
    input  logic          sda_s,
    input  logic [1:0]    strap_eff,
    input  logic [7:0]    rd_data,
    output logic [AW-1:0] ptr,
    output logic          wr_en,
    output logic [7:0]    wr_data,
    output logic          sda_pull,
    output logic          busy
);
    typedef struct packed {
        twm_state_e    state;
        logic [1:0]    idx;
        logic [3:0]    bcnt;
        logic [7:0]    sh;
        logic [AW-1:0] ptr;
        logic [7:0]    dat;
        logic          pend;
        logic          rw;
        logic          mack;
        logic [TW-1:0] timer;
        logic          pull;
    } core_t;

    core_t q, d;
    logic  scl_p_q, sda_p_q;
    logic  start_ev, stop_ev, scl_rise, scl_fall, sel_ok;

    assign start_ev = scl_s & scl_p_q & sda_p_q & ~sda_s;
    assign stop_ev  = scl_s & scl_p_q & ~sda_p_q & sda_s;
    assign scl_rise = scl_s & ~scl_p_q;
    assign scl_fall = ~scl_s & scl_p_q;
    assign sel_ok   = (q.sh[7:4] == TYPE_PREFIX) && (q.sh[2:1] == strap_eff);

    always_comb begin
        d     = q;
        wr_en = 1'b0;
        if (q.state == ST_PROG) begin
            if (q.timer == '0) d.state = ST_IDLE;
            else               d.timer = q.timer - 1'b1;
        end else if (start_ev) begin
            d.state = ST_RX;
            d.idx   = 2'd0;
            d.bcnt  = 4'd0;
            d.pend  = 1'b0;
            d.pull  = 1'b0;
        end else if (stop_ev) begin
            d.pull = 1'b0;
            if (q.pend) begin
                wr_en   = 1'b1;
                d.pend  = 1'b0;
                d.state = ST_PROG;
                d.timer = TW'(PROG_CYCLES - 1);
            end else begin
                d.state = ST_IDLE;
            end
        end else begin
            case (q.state)
                ST_RX: begin
                    if (scl_rise) begin
                        d.sh   = {q.sh[6:0], sda_s};
                        d.bcnt = q.bcnt + 1'b1;
                    end else if (scl_fall && q.bcnt == 4'd8) begin
                        d.state = ST_ACK;
                        d.pull  = 1'b1;
                        case (q.idx)
                            2'd0: begin
                                d.rw = q.sh[0];
                                if (!sel_ok) begin
                                    d.state = ST_IDLE;
                                    d.pull  = 1'b0;
                                end
                            end
                            2'd1, 2'd2: d.ptr = AW'({8'(q.ptr), q.sh});
                            default: begin
                                d.dat  = q.sh;
                                d.pend = 1'b1;
                            end
                        endcase
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        d.pull = 1'b0;
                        d.bcnt = 4'd0;
                        d.idx  = q.idx + 1'b1;
                        if (q.idx == 2'd0 && q.rw) begin
                            d.state = ST_TX;
                            d.sh    = rd_data;
                            d.pull  = ~rd_data[7];
                        end else if (q.idx == 2'd3) begin
                            d.state = ST_WAIT;
                        end else begin
                            d.state = ST_RX;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (q.bcnt == 4'd7) begin
                            d.state = ST_TXACK;
                            d.pull  = 1'b0;
                            d.ptr   = q.ptr + 1'b1;
                        end else begin
                            d.sh   = {q.sh[6:0], 1'b0};
                            d.bcnt = q.bcnt + 1'b1;
                            d.pull = ~q.sh[6];
                        end
                    end
                end
                ST_TXACK: begin
                    if (scl_rise) begin
                        d.mack = ~sda_s;
                    end else if (scl_fall) begin
                        if (q.mack) begin
                            d.state = ST_TX;
                            d.sh    = rd_data;
                            d.bcnt  = 4'd0;
                            d.pull  = ~rd_data[7];
                        end else begin
                            d.state = ST_WAIT;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '{state: ST_IDLE, default: '0};
            scl_p_q <= 1'b1;
            sda_p_q <= 1'b1;
        end else begin
            q       <= d;
            scl_p_q <= scl_s;
            sda_p_q <= sda_s;
        end
    end

    assign ptr      = q.ptr;
    assign wr_data  = q.dat;
    assign sda_pull = q.pull;
    assign busy     = (q.state == ST_PROG);

    a_r7_deaf_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !sda_pull);
    a_r8_drive_only_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_pull != $past(sda_pull)) |-> !scl_s);
    a_r6_stop_commits: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_ev && q.pend && !busy) |=> busy);
    a_r2_start_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        (start_ev && !busy) |=> (q.state == ST_RX && q.bcnt == 4'd0 && !q.pend));
    a_r3_mismatch_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_RX && q.idx == 2'd0 && scl_fall && q.bcnt == 4'd8
         && !start_ev && !stop_ev && q.sh[7:4] != TYPE_PREFIX) |=> !sda_pull);
endmodule

// File: rtl/twowire_mem_slave.sv
module twowire_mem_slave #(
    parameter int         MEM_DEPTH   = 256,
    parameter int         PROG_CYCLES = 1000,
    parameter logic [1:0] STRAP_USED  = 2'b11
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [1:0] strap_i,
    output logic       sda_pull_o,
    output logic       busy_o
);
    localparam int AW = $clog2(MEM_DEPTH);

    logic [1:0]    line_s;
    logic [1:0]    strap_eff;
    logic [AW-1:0] ptr;
    logic [7:0]    rd_data, wr_data;
    logic          wr_en;

    // R4: an unused strap position reads as logic 0
    assign strap_eff = strap_i & STRAP_USED;

    twm_sync #(.WIDTH(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i({scl_i, sda_i}), .sync_o(line_s)
    );

    twm_core #(.MEM_DEPTH(MEM_DEPTH), .PROG_CYCLES(PROG_CYCLES)) u_core (
        .clk(clk), .rst_n(rst_n), .scl_s(line_s[1]), .sda_s(line_s[0]),
        .strap_eff(strap_eff), .rd_data(rd_data), .ptr(ptr), .wr_en(wr_en),
        .wr_data(wr_data), .sda_pull(sda_pull_o), .busy(busy_o)
    );

    twm_mem #(.MEM_DEPTH(MEM_DEPTH)) u_mem (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(ptr),
        .wr_data(wr_data), .rd_addr(ptr), .rd_data(rd_data)
    );
endmodule

// File: tb/sim_twowire_mem_slave.sv
module sim_twowire_mem_slave;
    localparam int PROG = 400;
    localparam int H    = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic pull, busy, bus_sda;
    int   checks = 0, fails = 0, busy_cnt = 0, drive_viol = 0;
    logic pull_prev = 1'b0;

    always #10 clk = ~clk;
    assign bus_sda = m_sda & ~pull;

    twowire_mem_slave #(.MEM_DEPTH(256), .PROG_CYCLES(PROG), .STRAP_USED(2'b01)) u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(bus_sda),
        .strap_i(2'b11), .sda_pull_o(pull), .busy_o(busy)
    );

    always @(negedge clk) begin
        if (busy) busy_cnt <= busy_cnt + 1;
        if (pull != pull_prev && m_scl) drive_viol <= drive_viol + 1;
        pull_prev <= pull;
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic hw();
        repeat (H) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; hw(); m_scl = 1'b1; hw(); m_sda = 1'b0; hw(); m_scl = 1'b0; hw();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; hw(); m_scl = 1'b1; hw(); m_sda = 1'b1; hw();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; hw(); m_scl = 1'b1; hw(); m_scl = 1'b0; hw();
        end
        m_sda = 1'b1; hw(); m_scl = 1'b1; hw();
        acked = ~bus_sda;
        m_scl = 1'b0; hw();
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        m_sda = 1'b1;
        for (int i = 0; i < 8; i++) begin
            hw(); m_scl = 1'b1; hw(); b = {b[6:0], bus_sda}; m_scl = 1'b0;
        end
        hw(); m_sda = ~give_ack; hw(); m_scl = 1'b1; hw(); m_scl = 1'b0; hw();
        m_sda = 1'b1;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        hw();
    endtask

    task automatic write_one(input logic [15:0] a, input logic [7:0] v, input string req);
        logic ak;
        bus_start();
        send_byte(8'hA2, ak); check({req, " select ack"}, ak, 1);
        send_byte(a[15:8], ak); check({req, " addr hi ack"}, ak, 1);
        send_byte(a[7:0], ak);  check({req, " addr lo ack"}, ak, 1);
        send_byte(v, ak);       check({req, " data ack"}, ak, 1);
        check("R6 no commit before stop", busy, 0);
        bus_stop();
    endtask

    task automatic read_two(input logic [15:0] a, output logic [7:0] b0, output logic [7:0] b1);
        logic ak;
        bus_start();
        send_byte(8'hA2, ak);
        send_byte(a[15:8], ak);
        send_byte(a[7:0], ak);
        bus_start();
        send_byte(8'hA3, ak); check("R8 read select ack", ak, 1);
        recv_byte(1'b1, b0);
        recv_byte(1'b0, b1);
        check("R8 released after master nack", pull, 0);
        bus_stop();
    endtask

    task automatic t_reset();
        check("R5 reset pull", pull, 0);
        check("R5 reset busy", busy, 0);
    endtask

    task automatic t_no_start();
        logic ak;
        m_scl = 1'b0; hw();
        send_byte(8'hA2, ak);
        check("R1 no ack without start", ak, 0);
        m_scl = 1'b1; hw();
    endtask

    task automatic t_select();
        logic ak;
        bus_start(); send_byte(8'hB2, ak); check("R3 wrong prefix", ak, 0); bus_stop();
        bus_start(); send_byte(8'hAA, ak); check("R3 bit3 ignored", ak, 1); bus_stop();
        bus_start(); send_byte(8'hA6, ak); check("R4 unused strap reads 0", ak, 0); bus_stop();
        bus_start(); send_byte(8'hA0, ak); check("R3 A0 mismatch", ak, 0); bus_stop();
    endtask

    task automatic t_write_busy();
        logic ak;
        busy_cnt = 0;
        write_one(16'h0010, 8'h5C, "R6");
        hw();
        check("R7 busy after stop", busy, 1);
        bus_start(); send_byte(8'hA2, ak); check("R7 deaf while busy", ak, 0); bus_stop();
        wait_idle();
        check("R7 busy length", busy_cnt, PROG);
        write_one(16'h0011, 8'hA7, "R6");
        wait_idle();
    endtask

    task automatic t_read();
        logic [7:0] b0, b1;
        read_two(16'h0010, b0, b1);
        check("R8 first byte", b0, 8'h5C);
        check("R8 pointer advance", b1, 8'hA7);
        check("R8 sda only with scl low", drive_viol, 0);
    endtask

    task automatic t_alias();
        logic [7:0] b0, b1;
        write_one(16'h3F20, 8'h81, "R9");
        wait_idle();
        read_two(16'h0020, b0, b1);
        check("R9 high address bits ignored", b0, 8'h81);
    endtask

    task automatic t_abort();
        logic ak;
        logic [7:0] b0, b1;
        busy_cnt = 0;
        bus_start();
        send_byte(8'hA2, ak); send_byte(8'h00, ak); send_byte(8'h30, ak);
        send_byte(8'hEE, ak); check("R2 data acked", ak, 1);
        bus_start();
        bus_stop();
        repeat (3 * H) @(negedge clk);
        check("R2 no programming after abort", busy_cnt, 0);
        read_two(16'h0030, b0, b1);
        check("R2 aborted byte not written", b0, 8'h00);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset();
        t_no_start();
        t_select();
        t_write_busy();
        t_read();
        t_alias();
        t_abort();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule